// File: doc/BRIEF.md
# Oscillator Enable Guard

This block keeps the oscillator control bits that software writes: an enable for the fast oscillator, an enable for the slow oscillator, a main clock select, and a pin-assignment bit. The pin-assignment bit gives the fast oscillator pins either to the oscillator or to general-purpose port use. The block does not carry out a change of the select bit at once. It runs a timed hand-over and keeps a status copy of the clock that actually drives the system. A busy flag is high while the hand-over is pending.

Each cycle the block checks whether the present bits would leave the CPU with no running clock. It checks against both the selected clock and the clock still in use. When the bits enter such a state, it raises a one-cycle internal reset request. On the next cycle its own registers return to their power-on values, so the request cannot repeat.

Top module: `osc_guard`

## Requirements
- R1: When both the fast enable (bit 0 of the control word) and the slow enable (bit 1) are 0, rst_req is 1 in the cycle after the write.
- R2: When the slow enable is 0 while the slow clock is selected (bit 2 = 1) or is the active clock (act_lf = 1), rst_req is 1 in the cycle after the write.
- R3: When the fast enable is 0 while the fast clock is selected (bit 2 = 0) or is the active clock (act_lf = 0), rst_req is 1 in the cycle after the write.
- R4: When the fast enable is 1 and the pin bit (bit 3) is 0, meaning the pins are a port, rst_req is 1 in the cycle after the write.
- R5: After a legal write changes the select bit, sw_busy is 1 for exactly SW_DELAY cycles with act_lf unchanged. act_lf then takes the selected clock and sw_busy falls.
- R6: While a hand-over away from the fast clock is pending, a write that clears the fast enable raises rst_req, even though the slow clock is selected and enabled.
- R7: After rst_n is released, ctl_q is 4'b1001 (fast enabled and selected, slow disabled, pins to the oscillator), act_lf is 0, and sw_busy and rst_req are 0.
- R8: rst_req lasts one cycle. In the next cycle ctl_q is 4'b1001, act_lf is 0 and sw_busy is 0. A write presented in the request cycle is discarded.
- R9: A write that forms a legal combination never raises rst_req, including while a hand-over is pending. In the next cycle ctl_q equals the written word.
- R10: If the select bit is written back to the active clock before the hand-over completes, sw_busy falls in the next cycle and act_lf keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 4 | Control word: bit 0 fast enable, bit 1 slow enable, bit 2 select slow, bit 3 pins to oscillator |
| ctl_q | output | 4 | Current control word |
| act_lf | output | 1 | 1 when the slow clock is the active main clock |
| sw_busy | output | 1 | Clock hand-over pending |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
Two functions can meet in one cycle. One is the pending hand-over, which keeps the old clock active. The other is the illegal-state check, which must judge the bits against that old clock rather than the newly selected one. The bench starts a switch to the slow clock and then clears the fast enable partway through the delay. It expects a reset request even though the selected clock is enabled. In the opposite case, it rewrites a legal word during the delay and expects no request, with the busy flag still high. A second collision puts a write into the request cycle itself, and the bench expects the control word to return to its default rather than take that write.

// File: rtl/osc_guard_pkg.sv
package osc_guard_pkg;

  typedef struct packed {
    logic pin_osc;  // 1: fast oscillator pins belong to the oscillator
    logic sel_lf;   // 1: slow clock selected as main clock
    logic lf_en;    // slow oscillator enable
    logic hf_en;    // fast oscillator enable
  } osc_ctl_t;

  localparam osc_ctl_t CTL_DEFAULT = '{pin_osc: 1'b1, sel_lf: 1'b0, lf_en: 1'b0, hf_en: 1'b1};

endpackage

// File: rtl/osc_ctl_reg.sv
module osc_ctl_reg
  import osc_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     wr_en,
  input  osc_ctl_t wr_data,
  output osc_ctl_t q
);

  osc_ctl_t q_nxt;
  logic     q_ld;

  always_comb begin
    q_ld  = clr | wr_en;
    q_nxt = clr ? CTL_DEFAULT : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= CTL_DEFAULT;
    else if (q_ld) q <= q_nxt;
  end

  // R8: a reset request restores the default word and discards a concurrent write
  assert_clr_restores_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (q == CTL_DEFAULT));

endmodule

// File: rtl/osc_switch_timer.sv
module osc_switch_timer #(
  parameter int SW_DELAY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sel_lf,
  output logic act_lf,
  output logic busy
);

  localparam int CNT_W = (SW_DELAY > 1) ? $clog2(SW_DELAY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SW_DELAY - 1);

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             act_nxt;

  always_comb begin
    busy    = sel_lf ^ act_lf;
    act_nxt = act_lf;
    cnt_nxt = '0;
    if (clr) begin
      act_nxt = 1'b0;
    end else if (busy) begin
      if (cnt == LAST) act_nxt = sel_lf;
      else             cnt_nxt = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_lf <= 1'b0;
      cnt    <= '0;
    end else begin
      act_lf <= act_nxt;
      cnt    <= cnt_nxt;
    end
  end

  // R5: the active clock moves only after a pending hand-over or a reset request
  assert_act_moves_when_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_lf) |-> ($past(busy) || $past(clr)));

  // R5: the delay counter never passes its limit
  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/osc_illegal_det.sv
module osc_illegal_det
  import osc_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  osc_ctl_t ctl,
  input  logic     act_lf,
  output logic     illegal
);

  logic need_lf, need_hf;
  logic no_osc, lf_missing, hf_missing, pin_clash;

  always_comb begin
    need_lf    = ctl.sel_lf | act_lf;
    need_hf    = ~ctl.sel_lf | ~act_lf;
    no_osc     = ~ctl.hf_en & ~ctl.lf_en;
    lf_missing = need_lf & ~ctl.lf_en;
    hf_missing = need_hf & ~ctl.hf_en;
    pin_clash  = ctl.hf_en & ~ctl.pin_osc;
    illegal    = no_osc | lf_missing | hf_missing | pin_clash;
  end

  // R7: the power-on state is legal
  assert_default_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == CTL_DEFAULT && !act_lf) |-> !illegal);

  // R4: pins given to the port while the fast oscillator runs
  assert_pin_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.hf_en && !ctl.pin_osc) |-> illegal);

endmodule

// File: rtl/osc_guard.sv
module osc_guard
  import osc_guard_pkg::*;
#(
  parameter int SW_DELAY = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  output logic [3:0] ctl_q,
  output logic       act_lf,
  output logic       sw_busy,
  output logic       rst_req
);

  osc_ctl_t ctl;
  logic     illegal;

  osc_ctl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (illegal),
    .wr_en   (wr_en),
    .wr_data (osc_ctl_t'(wr_data)),
    .q       (ctl)
  );

  osc_switch_timer #(.SW_DELAY(SW_DELAY)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (illegal),
    .sel_lf (ctl.sel_lf),
    .act_lf (act_lf),
    .busy   (sw_busy)
  );

  osc_illegal_det u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .act_lf  (act_lf),
    .illegal (illegal)
  );

  assign ctl_q   = ctl;
  assign rst_req = illegal;

  // R8: the reset request is a single-cycle pulse
  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R8: the cycle after a request shows the default state
  assert_req_then_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (ctl_q == 4'b1001 && !act_lf && !sw_busy));

  // R6: during a pending switch the still-active fast clock must stay enabled
  assert_pending_active_hf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_busy && !act_lf && !ctl.hf_en) |-> rst_req);

endmodule

// File: tb/sim_osc_guard.sv
`timescale 1ns/1ps
module sim_osc_guard;

  localparam int DLY = 8;

  logic       clk, rst_n, wr_en;
  logic [3:0] wr_data, ctl_q;
  logic       act_lf, sw_busy, rst_req;

  int n_chk, n_err;

  osc_guard #(.SW_DELAY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_q(ctl_q), .act_lf(act_lf), .sw_busy(sw_busy), .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic bad(input logic [3:0] w, input logic a);
    logic h, l, s, p;
    {p, s, l, h} = w;
    return (!h && !l) || ((s || a) && !l) || ((!s || !a) && !h) || (h && !p);
  endfunction

  // drive at negedge, clock once, return at the following negedge
  task automatic wr(input logic [3:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 4'h0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 4'h0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_err = 0;
    do_reset();
    // R7 reset state
    chk("R7 ctl", {4'h0, ctl_q}, 8'h09);
    chk("R7 act/busy/req", {5'h0, act_lf, sw_busy, rst_req}, 8'h00);

    // R5 hand-over timing
    wr(4'b1111);
    chk("R9 no req on legal switch", {7'h0, rst_req}, 8'h0);
    for (int i = 0; i < DLY; i++) begin
      chk("R5 pending busy/act", {6'h0, sw_busy, act_lf}, 8'h02);
      @(negedge clk);
    end
    chk("R5 handed over", {6'h0, sw_busy, act_lf}, 8'h01);

    // R6 disable active fast clock during pending switch
    do_reset();
    wr(4'b1111);
    idle(3);
    wr(4'b1110);
    chk("R6 req during pending", {7'h0, rst_req}, 8'h1);
    @(negedge clk);
    chk("R8 after R6 req", {ctl_q, 1'b0, act_lf, sw_busy, rst_req}, 8'h90);

    // R9 legal rewrite during pending switch
    do_reset();
    wr(4'b1111);
    idle(2);
    wr(4'b1111);
    chk("R9 legal while pending", {6'h0, sw_busy, rst_req}, 8'h02);

    // R10 cancel by writing select back
    do_reset();
    wr(4'b1111);
    idle(3);
    wr(4'b1011);
    chk("R10 busy drops", {6'h0, sw_busy, act_lf}, 8'h00);
    idle(DLY + 2);
    chk("R10 act kept", {5'h0, sw_busy, act_lf, rst_req}, 8'h00);
    chk("R10 ctl kept", {4'h0, ctl_q}, 8'h0B);

    // R8 write in request cycle is discarded
    do_reset();
    wr(4'b0000);
    chk("R1 req on all off", {7'h0, rst_req}, 8'h1);
    wr(4'b1011);
    chk("R8 write in req cycle dropped", {ctl_q, 1'b0, act_lf, sw_busy, rst_req}, 8'h90);

    // exhaustive sweep: both active clocks, every written word (R1 R2 R3 R4 R9 R8)
    for (int a = 0; a < 2; a++) begin
      for (int w = 0; w < 16; w++) begin
        logic e;
        do_reset();
        if (a == 1) begin
          wr(4'b1111);
          idle(DLY + 1);
          wr(4'b1110);  // slow active, selected, enabled; fast off: legal
          chk("R9 slow-only setup", {6'h0, act_lf, rst_req}, 8'h02);
        end
        e = bad(4'(w), a[0]);
        wr(4'(w));
        if (e) begin
          chk("R1/R2/R3/R4 sweep req", {3'h0, a[0], 4'(w)} , {3'h0, a[0], 4'(w)} ^ {7'h0, ~rst_req});
          @(negedge clk);
          chk("R8 sweep default", {ctl_q, 1'b0, act_lf, sw_busy, rst_req}, 8'h90);
        end else begin
          chk("R9 sweep no req", {3'h0, a[0], 4'(w)}, {3'h0, a[0], 4'(w)} ^ {7'h0, rst_req});
          chk("R9 sweep ctl/busy", {ctl_q, 1'b0, act_lf, sw_busy, 1'b0},
              {4'(w), 1'b0, a[0], (w[2] != a), 1'b0});
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule